// File: doc/BRIEF.md
# Coprocessor Host Bus Front End

This block is the host-facing front end of a lookup coprocessor. The host drives a 32-bit bus with memory-like controls: chip enable, two chip selects, write and output enables, an address-valid line, a segment line and an address/control bus. The block decodes each sampled cycle into one of two things. The first is a random access to the lookup array. The second is a control-state operation. It sends single-cycle operation strobes towards the array. It receives the array's read data and its compare result flags.

The block has two control modes, chosen by a configuration register. In hardware mode the address/control bus carries the operation directly. In software mode the host writes an instruction word, and that word stays in force. Each later data cycle executes that instruction until the host writes a new one. A read with address-valid high returns a status word in either mode. Selection is the OR of two conditions: a low hardware chip select, or a match between a device-select register and the page field of the configuration register. This lets several devices share one bus.

Top module: `cop_host_port`

## Requirements
- R1: In hardware mode, an enabled cycle with `av_n` low is a random access. With `we_n` low, `mem_wr` pulses one cycle later and carries `mem_addr`=`ac`, `mem_seg`=`seg`, `op_data`=`dq_in` and `mem_vb_n`=`vb_in`. With `we_n` high, `mem_rd` pulses one cycle later with the same address and segment.
- R2: A read cycle drives `dq_oe` high in the cycle after it is sampled, but only if `ce_n` was low, the device was enabled and `oe_n` was low. An array read returns `arr_rdata` on `dq_out` and `arr_vld_n` on `vb_out`, where low on `vb_out` means valid and high means empty. While `dq_oe` is low, `dq_out` is 0 and `vb_out` is 1.
- R3: Configuration register layout: bits 1:0 are the mode, and bits PG_W+1:2 are the page. Mode 00 selects hardware control. Any other value selects software control. After reset the register is 0.
- R4: In hardware mode, an enabled write with `av_n` high carries control code `ac[11:0]`. Code 0x0F0 writes the configuration register from `dq_in`. Code 0x0F1 writes the device-select register. Any other code pulses `ctl_go` one cycle later with `ctl_code`=code, `ctl_seg`=`seg`, `ctl_wr`=1 and `op_data`=`dq_in`.
- R5: In software mode, an enabled write with `av_n` high loads the instruction from `dq_in`. Bits 11:0 are the code, bit 12 is the segment, and bit 13 is the expected `we_n` level (0 means a write-type instruction). `mem_rd` and `mem_wr` never pulse in software mode.
- R6: A loaded instruction whose code bit 11 is set needs no data transfer. It pulses `ctl_go` in the next cycle, with `ctl_wr` equal to the inverse of its bit 13.
- R7: In software mode, every enabled cycle with `av_n` low whose `we_n` equals the held level executes the held instruction. `ctl_go` pulses with the held code and segment, `ctl_wr`=!`we_n` and `op_data`=`dq_in`. Such reads return `arr_rdata`.
- R8: A read with `av_n` high returns the status word on `dq_out` and leaves the held instruction unchanged.
- R9: A software-mode data cycle is suppressed, with no strobe, and sets `err` if any of these holds: no instruction has been loaded, the held instruction has code bit 11 set, or `we_n` disagrees with the held level. `err` stays high until reset.
- R10: A cycle takes effect only if `ce_n` is low and the device is enabled. The device is enabled if `cs1_n` is low, or `cs2_n` is low, or device-select bit PG_W is set and device-select bits PG_W-1:0 equal the configuration page. A cycle that is not enabled produces no strobe and changes no register.
- R11: In hardware mode, a write of code 0x0F1 with `av_n` high and `ce_n` low loads the device-select register even when the device is not enabled.
- R12: The status word holds `res_addr` in bits AC_W-1:0, `res_match_n` in bit AC_W, `res_multi_n` in bit AC_W+1 and `res_full_n` in bit AC_W+2. It is loaded on each `res_valid` cycle. After reset the address is 0 and the flags are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| cs1_n | input | 1 | Hardware select 1, active low |
| cs2_n | input | 1 | Hardware select 2, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| av_n | input | 1 | Address valid, active low |
| seg | input | 1 | Data half select (0 low half, 1 high half) |
| ac | input | AC_W | Address / control bus |
| dq_in | input | DW | Host write data |
| vb_in | input | 1 | Validity bit written with data |
| dq_out | output | DW | Read data to host |
| dq_oe | output | 1 | Data bus drive enable |
| vb_out | output | 1 | Validity bit read back |
| arr_rdata | input | DW | Read data from array |
| arr_vld_n | input | 1 | Validity of the array read |
| mem_rd | output | 1 | Random read strobe |
| mem_wr | output | 1 | Random write strobe |
| mem_addr | output | AC_W | Random access address |
| mem_seg | output | 1 | Random access half |
| mem_vb_n | output | 1 | Validity bit to write |
| op_data | output | DW | Data for write or control operation |
| ctl_go | output | 1 | Control operation strobe |
| ctl_code | output | 12 | Control code |
| ctl_seg | output | 1 | Control operation half |
| ctl_wr | output | 1 | Control operation is a write |
| res_valid | input | 1 | Compare result valid |
| res_addr | input | AC_W | Match address |
| res_match_n | input | 1 | Match flag, active low |
| res_multi_n | input | 1 | Multiple match flag, active low |
| res_full_n | input | 1 | Full flag, active low |
| err | output | 1 | Sticky cycle-type error |

## Verification
The hardest case to reach from the ports is selection through the page match. No chip select is low, so the device is enabled only by register state that two separate writes must set up first. The stimulus first writes the device-select register as a broadcast while both selects are high. It then writes a matching page through a hardware select. After that it runs every later software-mode sequence with both selects high. Inside that sequence, status reads are placed between data cycles of a held instruction, and a deliberately wrong cycle type is inserted. These show that the instruction persists and that the error latches.

// File: rtl/cop_pkg.sv
package cop_pkg;
   localparam int CODE_W = 12;
   localparam int INSTR_W = CODE_W + 2;

   typedef struct packed {
      logic              wl;
      logic              seg;
      logic [CODE_W-1:0] code;
   } instr_t;

   typedef struct packed {
      logic              mem_rd;
      logic              mem_wr;
      logic              stat_rd;
      logic              arr_rd;
      logic              load;
      logic              exec;
      logic              bad;
      logic [CODE_W-1:0] ex_code;
      logic              ex_seg;
      logic              ex_wr;
   } dec_t;
endpackage

// File: rtl/cop_select.sv
module cop_select #(
   parameter int PG_W       = 4,
   parameter bit PAGE_MATCH = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [PG_W+1:0] cfg_d,
   input  logic          dsel_wr,
   input  logic [PG_W:0] dsel_d,
   input  logic          cs1_n,
   input  logic          cs2_n,
   output logic          hw_mode,
   output logic          sel
);
   localparam int CFG_W  = PG_W + 2;
   localparam int DSEL_W = PG_W + 1;

   logic [CFG_W-1:0]  cfg_q;
   logic [DSEL_W-1:0] dsel_q;
   logic              page_hit;

   if (PG_W < 1) begin : g_bad_pg
      $error("PG_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         dsel_q <= '0;
      end else begin
         if (cfg_wr)  cfg_q  <= cfg_d;
         if (dsel_wr) dsel_q <= dsel_d;
      end
   end

   if (PAGE_MATCH) begin : g_page
      assign page_hit = dsel_q[PG_W] && (dsel_q[PG_W-1:0] == cfg_q[CFG_W-1:2]);
   end else begin : g_nopage
      assign page_hit = 1'b0;
   end

   assign hw_mode = (cfg_q[1:0] == 2'b00);
   assign sel     = !cs1_n || !cs2_n || page_hit;

   // R3
   mode_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (hw_mode == ($past(cfg_d[1:0]) == 2'b00)));
endmodule

// File: rtl/cop_status.sv
module cop_status #(
   parameter int AC_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            res_valid,
   input  logic [AC_W-1:0] res_addr,
   input  logic            res_match_n,
   input  logic            res_multi_n,
   input  logic            res_full_n,
   output logic [AC_W+2:0] stat
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         stat <= {3'b111, {AC_W{1'b0}}};
      else if (res_valid) stat <= {res_full_n, res_multi_n, res_match_n, res_addr};
   end

   // R12
   status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |=> $stable(stat));
endmodule

// File: rtl/cop_decode.sv
module cop_decode
   import cop_pkg::*;
#(
   parameter int          AC_W      = 12,
   parameter logic [11:0] DSEL_CODE = 12'h0F1
) (
   input  logic              act,
   input  logic              en,
   input  logic              hw_mode,
   input  logic              av_n,
   input  logic              we_n,
   input  logic              seg,
   input  logic [CODE_W-1:0] ac_code,
   input  logic [INSTR_W-1:0] dq_lo,
   input  instr_t            instr,
   input  logic              instr_vld,
   output dec_t              dec
);
   always_comb begin
      dec = '0;
      if (act && !en && hw_mode && av_n && !we_n && ac_code == DSEL_CODE) begin
         dec.exec    = 1'b1;
         dec.ex_code = DSEL_CODE;
         dec.ex_seg  = seg;
         dec.ex_wr   = 1'b1;
      end else if (act && en) begin
         if (av_n && we_n) begin
            dec.stat_rd = 1'b1;
         end else if (hw_mode) begin
            if (av_n) begin
               dec.exec    = 1'b1;
               dec.ex_code = ac_code;
               dec.ex_seg  = seg;
               dec.ex_wr   = 1'b1;
            end else if (we_n) begin
               dec.mem_rd = 1'b1;
            end else begin
               dec.mem_wr = 1'b1;
            end
         end else if (av_n) begin
            dec.load = 1'b1;
            if (dq_lo[CODE_W-1]) begin
               dec.exec    = 1'b1;
               dec.ex_code = dq_lo[CODE_W-1:0];
               dec.ex_seg  = dq_lo[CODE_W];
               dec.ex_wr   = !dq_lo[CODE_W+1];
            end
         end else if (!instr_vld || instr.code[CODE_W-1] || (we_n != instr.wl)) begin
            dec.bad = 1'b1;
         end else begin
            dec.exec    = 1'b1;
            dec.ex_code = instr.code;
            dec.ex_seg  = instr.seg;
            dec.ex_wr   = !we_n;
            dec.arr_rd  = we_n;
         end
      end
   end
endmodule

// File: rtl/cop_host_port.sv
module cop_host_port
   import cop_pkg::*;
#(
   parameter int          AC_W       = 12,
   parameter int          DW         = 32,
   parameter int          PG_W       = 4,
   parameter bit          PAGE_MATCH = 1'b1,
   parameter logic [11:0] CFG_CODE   = 12'h0F0,
   parameter logic [11:0] DSEL_CODE  = 12'h0F1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ce_n,
   input  logic            cs1_n,
   input  logic            cs2_n,
   input  logic            we_n,
   input  logic            oe_n,
   input  logic            av_n,
   input  logic            seg,
   input  logic [AC_W-1:0] ac,
   input  logic [DW-1:0]   dq_in,
   input  logic            vb_in,
   output logic [DW-1:0]   dq_out,
   output logic            dq_oe,
   output logic            vb_out,
   input  logic [DW-1:0]   arr_rdata,
   input  logic            arr_vld_n,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic [AC_W-1:0] mem_addr,
   output logic            mem_seg,
   output logic            mem_vb_n,
   output logic [DW-1:0]   op_data,
   output logic            ctl_go,
   output logic [11:0]     ctl_code,
   output logic            ctl_seg,
   output logic            ctl_wr,
   input  logic            res_valid,
   input  logic [AC_W-1:0] res_addr,
   input  logic            res_match_n,
   input  logic            res_multi_n,
   input  logic            res_full_n,
   output logic            err
);
   localparam int STAT_W = AC_W + 3;
   localparam int PAD_W  = DW - STAT_W;

   if (AC_W < CODE_W) begin : g_bad_ac
      $error("AC_W must hold a full control code");
   end
   if (DW <= STAT_W || DW < INSTR_W || DW < PG_W + 2) begin : g_bad_dw
      $error("DW too narrow for status, instruction or configuration");
   end

   logic        hw_mode, sel, cfg_wr, dsel_wr, go;
   logic        instr_vld, src_stat;
   instr_t      instr_q;
   dec_t        dec;
   logic [STAT_W-1:0] stat;

   cop_select #(.PG_W(PG_W), .PAGE_MATCH(PAGE_MATCH)) u_sel (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(cfg_wr), .cfg_d(dq_in[PG_W+1:0]),
      .dsel_wr(dsel_wr), .dsel_d(dq_in[PG_W:0]),
      .cs1_n(cs1_n), .cs2_n(cs2_n),
      .hw_mode(hw_mode), .sel(sel)
   );

   cop_decode #(.AC_W(AC_W), .DSEL_CODE(DSEL_CODE)) u_dec (
      .act(!ce_n), .en(sel), .hw_mode(hw_mode),
      .av_n(av_n), .we_n(we_n), .seg(seg),
      .ac_code(ac[CODE_W-1:0]), .dq_lo(dq_in[INSTR_W-1:0]),
      .instr(instr_q), .instr_vld(instr_vld), .dec(dec)
   );

   cop_status #(.AC_W(AC_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid),
      .res_addr(res_addr), .res_match_n(res_match_n),
      .res_multi_n(res_multi_n), .res_full_n(res_full_n),
      .stat(stat)
   );

   assign cfg_wr  = dec.exec && dec.ex_wr && dec.ex_code == CFG_CODE;
   assign dsel_wr = dec.exec && dec.ex_wr && dec.ex_code == DSEL_CODE;
   assign go      = dec.exec && !cfg_wr && !dsel_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_rd    <= 1'b0;
         mem_wr    <= 1'b0;
         mem_addr  <= '0;
         mem_seg   <= 1'b0;
         mem_vb_n  <= 1'b1;
         op_data   <= '0;
         ctl_go    <= 1'b0;
         ctl_code  <= '0;
         ctl_seg   <= 1'b0;
         ctl_wr    <= 1'b0;
         instr_q   <= '0;
         instr_vld <= 1'b0;
         err       <= 1'b0;
         dq_oe     <= 1'b0;
         src_stat  <= 1'b0;
      end else begin
         mem_rd <= dec.mem_rd;
         mem_wr <= dec.mem_wr;
         ctl_go <= go;
         if (dec.mem_rd || dec.mem_wr) begin
            mem_addr <= ac;
            mem_seg  <= seg;
         end
         if (dec.mem_wr) mem_vb_n <= vb_in;
         if (dec.mem_wr || go) op_data <= dq_in;
         if (go) begin
            ctl_code <= dec.ex_code;
            ctl_seg  <= dec.ex_seg;
            ctl_wr   <= dec.ex_wr;
         end
         if (dec.load) begin
            instr_q   <= instr_t'(dq_in[INSTR_W-1:0]);
            instr_vld <= 1'b1;
         end
         if (dec.bad) err <= 1'b1;
         dq_oe    <= (dec.stat_rd || dec.mem_rd || dec.arr_rd) && !oe_n;
         src_stat <= dec.stat_rd;
      end
   end

   assign dq_out = !dq_oe ? '0 : (src_stat ? {{PAD_W{1'b0}}, stat} : arr_rdata);
   assign vb_out = (dq_oe && !src_stat) ? arr_vld_n : 1'b1;

   // R5
   mem_only_hw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> $past(hw_mode));

   // R9
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R1
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr, ctl_go}));

   // R2
   drive_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> $past(!oe_n && we_n && !ce_n));

   // R8
   stat_read_keeps_instr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(dec.stat_rd) |-> $stable(instr_q));
endmodule

// File: tb/cop_host_port_test.sv
`timescale 1ns/100ps
module cop_host_port_test;
   localparam logic [11:0] CFG  = 12'h0F0;
   localparam logic [11:0] DSEL = 12'h0F1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ce_n, cs1_n, cs2_n, we_n, oe_n, av_n, seg, vb_in, arr_vld_n;
   logic [11:0] ac;
   logic [31:0] dq_in, arr_rdata;
   logic res_valid, res_match_n, res_multi_n, res_full_n;
   logic [11:0] res_addr;
   logic [31:0] dq_out, op_data;
   logic dq_oe, vb_out, mem_rd, mem_wr, mem_seg, mem_vb_n;
   logic ctl_go, ctl_seg, ctl_wr, err;
   logic [11:0] mem_addr, ctl_code;

   int n_chk = 0, n_fail = 0;
   string tag = "R3";

   // reference state
   logic [5:0]  m_cfg;
   logic [4:0]  m_dsel;
   logic [13:0] m_instr;
   logic        m_iv, m_err;
   logic [14:0] m_stat;
   logic e_mrd, e_mwr, e_go, e_oe, e_stat, e_seg, e_vb, e_cseg, e_cwr;
   logic [11:0] e_addr, e_code;
   logic [31:0] e_data;

   always #2.5 clk = ~clk;

   cop_host_port uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cs1_n(cs1_n), .cs2_n(cs2_n),
      .we_n(we_n), .oe_n(oe_n), .av_n(av_n), .seg(seg), .ac(ac),
      .dq_in(dq_in), .vb_in(vb_in), .dq_out(dq_out), .dq_oe(dq_oe),
      .vb_out(vb_out), .arr_rdata(arr_rdata), .arr_vld_n(arr_vld_n),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_seg(mem_seg),
      .mem_vb_n(mem_vb_n), .op_data(op_data), .ctl_go(ctl_go),
      .ctl_code(ctl_code), .ctl_seg(ctl_seg), .ctl_wr(ctl_wr),
      .res_valid(res_valid), .res_addr(res_addr), .res_match_n(res_match_n),
      .res_multi_n(res_multi_n), .res_full_n(res_full_n), .err(err)
   );

   task automatic check(input string req, input logic [63:0] a, input logic [63:0] e);
      n_chk++;
      if (a !== e) begin
         n_fail++;
         $display("FAIL %s (scenario %s): actual %h expected %h", req, tag, a, e);
      end
   endtask

   task automatic idle();
      ce_n = 1; cs1_n = 1; cs2_n = 1; we_n = 1; oe_n = 1; av_n = 1; seg = 0;
      ac = '0; dq_in = '0; vb_in = 1; res_valid = 0;
   endtask

   task automatic model();
      logic act, hw, en, ex, ewr, eseg, rd;
      logic [11:0] code;
      act = !ce_n; hw = (m_cfg[1:0] == 2'b00);
      en = act && (!cs1_n || !cs2_n || (m_dsel[4] && m_dsel[3:0] == m_cfg[5:2]));
      ex = 0; ewr = 0; eseg = 0; rd = 0; code = '0;
      e_mrd = 0; e_mwr = 0; e_go = 0; e_stat = 0;
      if (act && !en && hw && av_n && !we_n && ac == DSEL) m_dsel = dq_in[4:0];
      else if (en) begin
         if (av_n && we_n) begin rd = 1; e_stat = 1; end
         else if (hw) begin
            if (av_n) begin ex = 1; code = ac; eseg = seg; ewr = 1; end
            else begin
               e_addr = ac; e_seg = seg;
               if (we_n) begin e_mrd = 1; rd = 1; end
               else begin e_mwr = 1; e_data = dq_in; e_vb = vb_in; end
            end
         end else if (av_n) begin
            m_instr = dq_in[13:0]; m_iv = 1;
            if (dq_in[11]) begin ex = 1; code = dq_in[11:0]; eseg = dq_in[12]; ewr = !dq_in[13]; end
         end else if (!m_iv || m_instr[11] || we_n != m_instr[13]) m_err = 1;
         else begin ex = 1; code = m_instr[11:0]; eseg = m_instr[12]; ewr = !we_n; rd = we_n; end
      end
      if (ex) begin
         if (ewr && code == CFG) m_cfg = dq_in[5:0];
         else if (ewr && code == DSEL) m_dsel = dq_in[4:0];
         else begin e_go = 1; e_code = code; e_cseg = eseg; e_cwr = ewr; e_data = dq_in; end
      end
      e_oe = rd && !oe_n;
      if (res_valid) m_stat = {res_full_n, res_multi_n, res_match_n, res_addr};
   endtask

   task automatic compare();
      logic [32:0] exp_bus;
      check("R1", {mem_rd, mem_wr}, {e_mrd, e_mwr});
      if (e_mrd || e_mwr) check("R1", {mem_addr, mem_seg}, {e_addr, e_seg});
      if (e_mwr) check("R1", {op_data, mem_vb_n}, {e_data, e_vb});
      check("R4", ctl_go, e_go);
      if (e_go) check("R4", {ctl_code, ctl_seg, ctl_wr, op_data}, {e_code, e_cseg, e_cwr, e_data});
      check("R2", dq_oe, e_oe);
      if (!e_oe) exp_bus = {32'h0, 1'b1};
      else if (e_stat) exp_bus = {17'h0, m_stat, 1'b1};
      else exp_bus = {arr_rdata, arr_vld_n};
      check("R2", {dq_out, vb_out}, exp_bus);
      check("R9", err, m_err);
   endtask

   task automatic step();
      @(posedge clk);
      model();
      @(negedge clk);
      compare();
      idle();
   endtask

   task automatic bus(input logic c1, input logic w, input logic o, input logic a,
                      input logic s, input logic [11:0] adr, input logic [31:0] d);
      ce_n = 0; cs1_n = c1; cs2_n = 1; we_n = w; oe_n = o; av_n = a;
      seg = s; ac = adr; dq_in = d;
      step();
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      idle();
      arr_rdata = 32'h1234_5678; arr_vld_n = 0;
      res_addr = '0; res_match_n = 1; res_multi_n = 1; res_full_n = 1;
      m_cfg = '0; m_dsel = '0; m_instr = '0; m_iv = 0; m_err = 0;
      m_stat = {3'b111, 12'h0};
      e_mrd = 0; e_mwr = 0; e_go = 0; e_oe = 0; e_stat = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R3 R12: reset state
      compare();
      check("R12", {dq_oe, vb_out}, {1'b0, 1'b1});

      tag = "R1"; vb_in = 0;
      bus(0, 0, 1, 0, 1, 12'h005, 32'hDEAD_BEEF);
      bus(0, 1, 1, 0, 0, 12'h007, 32'h0);
      tag = "R2";
      bus(0, 1, 0, 0, 0, 12'h009, 32'h0);
      arr_vld_n = 1; arr_rdata = 32'h0BAD_F00D;
      bus(0, 1, 0, 0, 1, 12'h00A, 32'h0);
      bus(0, 1, 1, 0, 0, 12'h00B, 32'h0);

      tag = "R10";
      bus(1, 0, 1, 0, 0, 12'h011, 32'h5555);
      bus(1, 0, 1, 1, 0, CFG, 32'h0000_0001);
      ce_n = 1; cs1_n = 0; we_n = 0; av_n = 0; ac = 12'h012; step();
      bus(0, 0, 1, 0, 0, 12'h013, 32'h6666);

      tag = "R11";
      bus(1, 0, 1, 1, 0, DSEL, 32'h0000_0013);
      tag = "R10";
      bus(0, 0, 1, 1, 0, CFG, 32'h0000_000C);
      bus(1, 1, 0, 0, 1, 12'h021, 32'h0);
      bus(1, 0, 1, 0, 0, 12'h022, 32'h7777);

      tag = "R4";
      bus(1, 0, 1, 1, 1, 12'h123, 32'hCAFE_0001);
      bus(0, 0, 1, 1, 0, 12'h7FF, 32'hCAFE_0002);

      tag = "R12";
      res_valid = 1; res_addr = 12'h02A; res_match_n = 0; res_multi_n = 1; res_full_n = 0;
      step();
      bus(1, 1, 0, 1, 0, 12'h0, 32'h0);
      bus(1, 1, 0, 1, 0, 12'h0, 32'h0);

      tag = "R3";
      bus(1, 0, 1, 1, 0, CFG, 32'h0000_000D);
      tag = "R5";
      bus(1, 0, 1, 0, 0, 12'h031, 32'h1111);
      bus(1, 0, 1, 1, 0, 12'h0, 32'h0000_1045);
      tag = "R7";
      bus(1, 0, 1, 0, 0, 12'h032, 32'hA1A1_1111);
      bus(1, 0, 1, 0, 1, 12'h033, 32'hA2A2_2222);
      tag = "R8";
      bus(1, 1, 0, 1, 0, 12'h0, 32'h0);
      bus(1, 0, 1, 0, 0, 12'h0, 32'hA3A3_3333);
      tag = "R7";
      arr_rdata = 32'hAAAA_5555; arr_vld_n = 0;
      bus(1, 0, 1, 1, 0, 12'h0, 32'h0000_2046);
      bus(1, 1, 0, 0, 0, 12'h0, 32'h0);
      bus(1, 1, 0, 0, 0, 12'h0, 32'h0);

      tag = "R6";
      bus(1, 0, 1, 1, 0, 12'h0, 32'h0000_3855);
      bus(1, 0, 1, 1, 0, 12'h0, 32'h0000_0801);
      tag = "R9";
      bus(1, 0, 1, 0, 0, 12'h0, 32'h4444);
      bus(1, 0, 1, 1, 0, 12'h0, 32'h0000_0046);
      bus(1, 1, 0, 0, 0, 12'h0, 32'h0);
      bus(1, 0, 1, 0, 0, 12'h0, 32'h4545);
      bus(1, 1, 1, 1, 0, 12'h0, 32'h0);

      tag = "R3";
      bus(1, 0, 1, 1, 0, 12'h0, 32'h0000_00F0);
      bus(1, 0, 1, 0, 0, 12'h0, 32'h0000_000C);
      bus(1, 0, 1, 0, 1, 12'h03C, 32'h8888);
      tag = "R10";
      bus(0, 0, 1, 1, 0, DSEL, 32'h0000_0000);
      bus(1, 0, 1, 0, 0, 12'h03D, 32'h9999);
      bus(0, 1, 0, 0, 1, 12'h03E, 32'h0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule